// File: doc/BRIEF.md
# Serial Transition-Coded Token Link

This block is a transmitter and receiver pair for a point-to-point link. Each direction uses two wires. A token carries a data byte and a control flag. It travels as ten symbols, and each symbol is a single level change on one of the two wires. One wire carries zeros and the other carries ones. The static level of a wire carries no information, so the link needs no DC balance or clock recovery. It only needs the receiver to see each change.

The transmitter accepts tokens through a valid/ready handshake. Two programmable fields set the pacing, both counted in system clock cycles:
- the spacing between symbols within a token;
- the spacing between the last symbol of one token and the first symbol of the next.

The receiver does the following:
- passes both incoming wires through a flop synchronizer;
- detects each change and rebuilds the token;
- checks even parity;
- reports a symbol error when both wires change in the same sample.

A resync input clears a partially received token.

Top module: `tlink_serial`

## Requirements
- R1: After reset both transmit wires are low, `tx_ready` is high, and `rx_valid`, `rx_par_err` and `rx_sym_err` are low.
- R2: Each transmitted symbol toggles exactly one wire: `tx_w1` for a 1 and `tx_w0` for a 0. The two transmit wires never toggle in the same cycle.
- R3: A token is sent as ten symbols in this order:
  - eight data bits, least significant first;
  - then the control flag;
  - then a parity bit chosen so that the number of 1 symbols among the ten is even.
- R4: A token is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and its first symbol appears on that same edge. `tx_ready` stays low until the last symbol has gone out and the token gap has elapsed. While `tx_ready` is high and `tx_valid` is low, the wires hold their levels.
- R5: Consecutive symbols of one token are exactly `sym_gap` cycles apart.
- R6: The first symbol of a token comes at least `tok_gap` cycles after the last symbol of the previous token. When `tx_valid` is held high, it comes exactly `tok_gap` cycles after.
- R7: A gap value below 2 behaves as 2, and a value above 2049 behaves as 2049.
- R8: Once the receiver has seen ten single-wire transitions, it pulses `rx_valid` for one cycle. During that cycle it presents the decoded byte on `rx_data` and the flag on `rx_ctrl`. A token sent by the transmitter and looped back is reproduced unchanged.
- R9: A token whose ten symbols hold an odd number of ones is still delivered. `rx_par_err` is high in the same cycle as `rx_valid`, and it is never high without `rx_valid`.
- R10: When both receive wires change in the same sample, `rx_sym_err` pulses for one cycle without `rx_valid`. The partial token is discarded, and the next ten symbols form a fresh token.
- R11: A high `rx_resync` discards any partial token, so the next ten symbols form a fresh token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Token offered for transmission |
| tx_ready | output | 1 | Transmitter can take a token this cycle |
| tx_data | input | DATA_W | Data byte to send |
| tx_ctrl | input | 1 | Control flag to send |
| sym_gap | input | GAP_W | Cycles between symbols within a token |
| tok_gap | input | GAP_W | Cycles from the last symbol of a token to the next token |
| tx_w0 | output | 1 | Transmit wire that toggles for a 0 symbol |
| tx_w1 | output | 1 | Transmit wire that toggles for a 1 symbol |
| rx_w0 | input | 1 | Receive wire whose toggle means 0 |
| rx_w1 | input | 1 | Receive wire whose toggle means 1 |
| rx_resync | input | 1 | Discard any partial received token |
| rx_valid | output | 1 | One-cycle pulse when a token is complete |
| rx_data | output | DATA_W | Received data byte |
| rx_ctrl | output | 1 | Received control flag |
| rx_par_err | output | 1 | Parity mismatch on the delivered token |
| rx_sym_err | output | 1 | Both wires changed in one sample |

## Verification
The bench decodes the transmit wires with its own model and times every transition. This would expose a transmitter that sends bits most significant first, places parity on the wrong side of the flag, or drifts its gaps by a cycle. Gap settings of 0, 1, 3000 and 4000 target clamping: a design without the clamp would either stall or emit symbols back to back. Transitions injected on top of the looped-back wires produce three cases:
- a parity error, which a faulty receiver would drop;
- a double transition, which a faulty receiver would absorb into the next token and so shift every bit;
- a resync request, which a faulty receiver would ignore and then deliver a token built from stale symbols.

// File: rtl/tlink_pkg.sv
package tlink_pkg;

   localparam int unsigned GAP_MIN = 2;
   localparam int unsigned GAP_MAX = 2049;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

endpackage

// File: rtl/tlink_sync.sv
module tlink_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("tlink_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/tlink_tx.sv
module tlink_tx
   import tlink_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int GAP_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   output logic              ready,
   input  logic [DATA_W-1:0] data,
   input  logic              ctrl,
   input  logic [GAP_W-1:0]  sym_gap,
   input  logic [GAP_W-1:0]  tok_gap,
   output logic              w0,
   output logic              w1
);

   localparam int SYMS  = DATA_W + 2;
   localparam int IDX_W = $clog2(SYMS);
   localparam logic [GAP_W-1:0] GAP_LO = GAP_W'(GAP_MIN);
   localparam logic [GAP_W-1:0] GAP_HI = GAP_W'(GAP_MAX);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYMS - 1);

   // Wait count loaded after a toggle: the clamped gap minus one.
   function automatic logic [GAP_W-1:0] wait_load(input logic [GAP_W-1:0] g);
      logic [GAP_W-1:0] c;
      c = (g < GAP_LO) ? GAP_LO : ((g > GAP_HI) ? GAP_HI : g);
      return c - 1'b1;
   endfunction

   tx_state_e         st_q;
   logic [SYMS-1:0]   frame_q;
   logic [SYMS-1:0]   frame_d;
   logic [IDX_W-1:0]  idx_q;
   logic [GAP_W-1:0]  wait_q;
   logic              w0_q, w1_q;

   assign frame_d = {^{ctrl, data}, ctrl, data};
   assign ready   = (st_q == TX_IDLE) && (wait_q == '0);
   assign w0      = w0_q;
   assign w1      = w1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         frame_q <= '0;
         idx_q   <= '0;
         wait_q  <= '0;
         w0_q    <= 1'b0;
         w1_q    <= 1'b0;
      end else if (wait_q != '0) begin
         wait_q <= wait_q - 1'b1;
      end else begin
         case (st_q)
            TX_IDLE: begin
               if (valid) begin
                  w0_q    <= w0_q ^ ~frame_d[0];
                  w1_q    <= w1_q ^ frame_d[0];
                  frame_q <= frame_d >> 1;
                  idx_q   <= IDX_W'(1);
                  wait_q  <= wait_load(sym_gap);
                  st_q    <= TX_SEND;
               end
            end
            default: begin
               w0_q    <= w0_q ^ ~frame_q[0];
               w1_q    <= w1_q ^ frame_q[0];
               frame_q <= frame_q >> 1;
               if (idx_q == LAST_IDX) begin
                  idx_q  <= '0;
                  wait_q <= wait_load(tok_gap);
                  st_q   <= TX_IDLE;
               end else begin
                  idx_q  <= idx_q + 1'b1;
                  wait_q <= wait_load(sym_gap);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/tlink_rx.sv
module tlink_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s0,
   input  logic              s1,
   input  logic              resync,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              ctrl,
   output logic              par_err,
   output logic              sym_err
);

   localparam int SYMS  = DATA_W + 2;
   localparam int IDX_W = $clog2(SYMS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYMS - 1);

   logic              p0_q, p1_q;
   logic              e0, e1;
   logic [SYMS-2:0]   acc_q;
   logic [IDX_W-1:0]  idx_q;
   logic [SYMS-1:0]   full;

   assign e0   = s0 ^ p0_q;
   assign e1   = s1 ^ p1_q;
   assign full = {e1, acc_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p0_q    <= 1'b0;
         p1_q    <= 1'b0;
         acc_q   <= '0;
         idx_q   <= '0;
         valid   <= 1'b0;
         data    <= '0;
         ctrl    <= 1'b0;
         par_err <= 1'b0;
         sym_err <= 1'b0;
      end else begin
         p0_q    <= s0;
         p1_q    <= s1;
         valid   <= 1'b0;
         par_err <= 1'b0;
         sym_err <= 1'b0;
         if (resync) begin
            idx_q <= '0;
         end else if (e0 && e1) begin
            sym_err <= 1'b1;
            idx_q   <= '0;
         end else if (e0 || e1) begin
            if (idx_q == LAST_IDX) begin
               valid   <= 1'b1;
               data    <= full[DATA_W-1:0];
               ctrl    <= full[DATA_W];
               par_err <= ^full;
               idx_q   <= '0;
            end else begin
               acc_q[idx_q] <= e1;
               idx_q        <= idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tlink_serial.sv
module tlink_serial
   import tlink_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int GAP_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_ctrl,
   input  logic [GAP_W-1:0]  sym_gap,
   input  logic [GAP_W-1:0]  tok_gap,
   output logic              tx_w0,
   output logic              tx_w1,
   input  logic              rx_w0,
   input  logic              rx_w1,
   input  logic              rx_resync,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ctrl,
   output logic              rx_par_err,
   output logic              rx_sym_err
);

   localparam longint GAP_CAP = (64'd1 << GAP_W) - 1;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (GAP_CAP < GAP_MAX) begin : g_bad_gap
         $error("GAP_W too narrow for the largest gap");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] rx_sync;

   tlink_tx #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (tx_valid),
      .ready   (tx_ready),
      .data    (tx_data),
      .ctrl    (tx_ctrl),
      .sym_gap (sym_gap),
      .tok_gap (tok_gap),
      .w0      (tx_w0),
      .w1      (tx_w1)
   );

   tlink_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_w1, rx_w0}),
      .q     (rx_sync)
   );

   tlink_rx #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .s0      (rx_sync[0]),
      .s1      (rx_sync[1]),
      .resync  (rx_resync),
      .valid   (rx_valid),
      .data    (rx_data),
      .ctrl    (rx_ctrl),
      .par_err (rx_par_err),
      .sym_err (rx_sym_err)
   );

endmodule

// File: rtl/tlink_serial_chk.sv
module tlink_serial_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic tx_w0,
   input logic tx_w1,
   input logic rx_valid,
   input logic rx_par_err,
   input logic rx_sym_err
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_ONE_WIRE_TX: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !((tx_w0 != $past(tx_w0)) && (tx_w1 != $past(tx_w1)))); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(tx_ready) && !$past(tx_valid))
         |-> (tx_w0 == $past(tx_w0)) && (tx_w1 == $past(tx_w1))); // R4

   AST_ACCEPT_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(tx_valid && tx_ready))
         |-> (((tx_w0 ^ $past(tx_w0)) ^ (tx_w1 ^ $past(tx_w1))) == 1'b1)); // R4

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready); // R4

   AST_PERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rx_par_err |-> rx_valid); // R9

   AST_SYMERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sym_err |-> !rx_valid); // R10

endmodule

bind tlink_serial tlink_serial_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_w0      (tx_w0),
   .tx_w1      (tx_w1),
   .rx_valid   (rx_valid),
   .rx_par_err (rx_par_err),
   .rx_sym_err (rx_sym_err)
);

// File: tb/tlink_serial_bench.sv
module tlink_serial_bench;

   localparam int DW = 8;
   localparam int GW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic [DW-1:0] tx_data = '0;
   logic          tx_ctrl = 1'b0;
   logic [GW-1:0] sym_gap = GW'(3);
   logic [GW-1:0] tok_gap = GW'(5);
   logic          tx_w0, tx_w1;
   logic          inj0 = 1'b0, inj1 = 1'b0;
   logic          rx_resync = 1'b0;
   logic          rx_valid;
   logic [DW-1:0] rx_data;
   logic          rx_ctrl, rx_par_err, rx_sym_err;

   always #2 clk = ~clk;

   tlink_serial u_tlink_serial (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .tx_data    (tx_data),
      .tx_ctrl    (tx_ctrl),
      .sym_gap    (sym_gap),
      .tok_gap    (tok_gap),
      .tx_w0      (tx_w0),
      .tx_w1      (tx_w1),
      .rx_w0      (tx_w0 ^ inj0),
      .rx_w1      (tx_w1 ^ inj1),
      .rx_resync  (rx_resync),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_ctrl    (rx_ctrl),
      .rx_par_err (rx_par_err),
      .rx_sym_err (rx_sym_err)
   );

   int n_chk = 0, n_fail = 0, n_symerr = 0, cyc = 0;
   bit b2b_next = 1'b0;
   logic [9:0] exp_tx[$];   // {b2b, ctrl, data}
   logic [9:0] exp_rx[$];   // {par_err, ctrl, data}

   function automatic int eff_gap(input logic [GW-1:0] g);
      if (g < 2) return 2;
      if (g > 2049) return 2049;
      return int'(g);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Watchdog
   always @(negedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 190000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // Transmit-wire model: decode and time every symbol
   logic       pw0 = 1'b0, pw1 = 1'b0;
   int         last_t = 0, k = 0;
   bit         have_last = 1'b0, cur_b2b = 1'b0;
   logic [9:0] bits = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((tx_w0 !== pw0) && (tx_w1 !== pw1)) begin
            chk(1'b0, "R2", "both wires toggled", 2, 1);
         end else if ((tx_w0 !== pw0) || (tx_w1 !== pw1)) begin
            if (k == 0) begin
               if (exp_tx.size() == 0) chk(1'b0, "R3", "unexpected symbol", 1, 0);
               else cur_b2b = exp_tx[0][9];
               if (have_last) begin
                  if (cur_b2b)
                     chk((cyc - last_t) == eff_gap(tok_gap),
                         (tok_gap < 2 || tok_gap > 2049) ? "R7" : "R6", "token gap",
                         cyc - last_t, eff_gap(tok_gap));
                  else
                     chk((cyc - last_t) >= 2, "R6", "token gap min", cyc - last_t, 2);
               end
            end else begin
               chk((cyc - last_t) == eff_gap(sym_gap),
                   (sym_gap < 2 || sym_gap > 2049) ? "R7" : "R5", "symbol gap",
                   cyc - last_t, eff_gap(sym_gap));
            end
            bits[k] = (tx_w1 !== pw1);
            k++;
            have_last = 1'b1;
            last_t = cyc;
            if (k == 10) begin
               k = 0;
               if (exp_tx.size() != 0) begin
                  logic [9:0] e;
                  e = exp_tx.pop_front();
                  chk(bits[7:0] == e[7:0], "R3", "data bits LSB first",
                      int'(bits[7:0]), int'(e[7:0]));
                  chk(bits[8] == e[8], "R3", "control symbol", int'(bits[8]), int'(e[8]));
                  chk((^bits) == 1'b0, "R3", "even ones count", int'(^bits), 0);
               end
            end
         end
      end
      pw0 = tx_w0;
      pw1 = tx_w1;
   end

   // Receiver output model
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_sym_err) n_symerr++;
         if (rx_valid) begin
            if (exp_rx.size() == 0) begin
               chk(1'b0, "R8", "unexpected rx_valid", 1, 0);
            end else begin
               logic [9:0] e;
               e = exp_rx.pop_front();
               chk(rx_data == e[7:0], "R8", "rx_data", int'(rx_data), int'(e[7:0]));
               chk(rx_ctrl == e[8], "R8", "rx_ctrl", int'(rx_ctrl), int'(e[8]));
               chk(rx_par_err == e[9], "R9", "rx_par_err", int'(rx_par_err), int'(e[9]));
            end
         end
      end
   end

   task automatic send(input logic [7:0] d, input logic c, input bit hold);
      tx_valid = 1'b1;
      tx_data  = d;
      tx_ctrl  = c;
      while (!tx_ready) @(negedge clk);
      exp_tx.push_back({b2b_next, c, d});
      exp_rx.push_back({1'b0, c, d});
      b2b_next = hold;
      @(negedge clk);
      if (!hold) tx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!(tx_ready && exp_tx.size() == 0)) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic inj_sym(input logic b);
      @(negedge clk);
      if (b) inj1 = ~inj1;
      else   inj0 = ~inj0;
      repeat (3) @(negedge clk);
   endtask

   task automatic inj_token(input logic [7:0] d, input logic c, input logic p);
      for (int i = 0; i < 8; i++) inj_sym(d[i]);
      inj_sym(c);
      inj_sym(p);
      repeat (8) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_w0 == 1'b0, "R1", "tx_w0", int'(tx_w0), 0);
      chk(tx_w1 == 1'b0, "R1", "tx_w1", int'(tx_w1), 0);
      chk(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
      chk(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
      chk(rx_sym_err == 1'b0 && rx_par_err == 1'b0, "R1", "rx flags", 1, 0);

      // Directed: tightest gaps, extreme patterns
      sym_gap = GW'(2);
      tok_gap = GW'(2);
      send(8'h00, 1'b1, 1'b1);
      send(8'hFF, 1'b0, 1'b1);
      send(8'hA5, 1'b1, 1'b0);
      wait_idle();

      // Random bursts with random gaps
      for (int b = 0; b < 6; b++) begin
         int n;
         sym_gap = GW'(2 + $urandom_range(0, 10));
         tok_gap = GW'(2 + $urandom_range(0, 28));
         n = 1 + $urandom_range(0, 4);
         for (int i = 0; i < n; i++)
            send(8'($urandom), 1'($urandom), i != n - 1);
         repeat ($urandom_range(0, 20)) @(negedge clk);
         wait_idle();
      end

      // R7: clamp of low symbol gap and high token gap
      sym_gap = GW'(0);
      tok_gap = GW'(4000);
      send(8'h3C, 1'b0, 1'b1);
      send(8'hC3, 1'b1, 1'b0);
      wait_idle();
      // R7: clamp of high symbol gap and low token gap
      sym_gap = GW'(3000);
      tok_gap = GW'(1);
      send(8'h81, 1'b0, 1'b1);
      send(8'h7E, 1'b1, 1'b0);
      wait_idle();
      sym_gap = GW'(3);
      tok_gap = GW'(3);
      repeat (10) @(negedge clk);

      // R9: parity error still delivers the token
      exp_rx.push_back({1'b1, 1'b0, 8'h3C});
      inj_token(8'h3C, 1'b0, 1'b1);

      // R10: both wires change together, partial token discarded
      for (int i = 0; i < 4; i++) inj_sym(1'b1);
      @(negedge clk);
      inj0 = ~inj0;
      inj1 = ~inj1;
      repeat (10) @(negedge clk);
      chk(n_symerr == 1, "R10", "symbol error pulses", n_symerr, 1);
      exp_rx.push_back({1'b0, 1'b1, 8'h96});
      inj_token(8'h96, 1'b1, ^{1'b1, 8'h96});

      // R11: resync discards a partial token
      for (int i = 0; i < 5; i++) inj_sym(1'b0);
      repeat (6) @(negedge clk);
      rx_resync = 1'b1;
      @(negedge clk);
      rx_resync = 1'b0;
      exp_rx.push_back({1'b0, 1'b0, 8'h5A});
      inj_token(8'h5A, 1'b0, ^{1'b0, 8'h5A});

      // Random injected tokens, some with bad parity
      for (int i = 0; i < 8; i++) begin
         logic [7:0] d;
         logic c, bad;
         d = 8'($urandom);
         c = 1'($urandom);
         bad = 1'($urandom);
         exp_rx.push_back({bad, c, d});
         inj_token(d, c, (^{c, d}) ^ bad);
      end

      repeat (20) @(negedge clk);
      chk(exp_rx.size() == 0, "R8", "tokens left undelivered", exp_rx.size(), 0);
      chk(exp_tx.size() == 0, "R3", "tokens left unsent", exp_tx.size(), 0);
      chk(n_symerr == 1, "R10", "total symbol errors", n_symerr, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule